// File: doc/BRIEF.md
# Low-Power-Aware Watchdog Timer

This block is a watchdog countdown timer that asks for a system reset when software stops servicing it. A 16-bit down-counter steps once per prescaler tick. The prescaler divides the bus clock by 1, 16, 256 or 1024. When the counter runs out, the block drives a one-cycle reset request and reloads the counter from the timeout register. Software keeps the timer alive with a two-write service sequence.

The counter reacts to the chip's power state and debug state. In wait mode and in stop mode it either keeps counting, so that its expiry can wake the chip, or it halts and reloads. A separate enable bit for each of the two modes selects which. While a debugger holds the chip, the counter freezes. Reads of the run-enable bit show 0 during debug, but the stored bit is kept.

A second path watches a loss-of-reference-clock input. When that input is seen with its enable set, a 7-bit backup counter starts on the bus clock and cannot be stopped. Each time it reaches 127 it raises the same reset request.

Top module: `lpwd_top`

## Requirements
- R1: After reset, reads return control 0x0031 (run enable set, prescaler select 2'b11, other enables clear), timeout 0xFFFF and counter 0xFFFF.
- R2: The control register is at address 0, with bit 0 run enable, bit 1 wait enable, bit 2 stop enable, bit 3 loss-clock enable and bits 5:4 prescaler select (00 gives /1, 01 gives /16, 10 gives /256, 11 gives /1024). While counting, the counter decrements once per divisor cycles of the bus clock.
- R3: The counter changes only by a one-step decrement or by a reload to the timeout value. After a reload to timeout T (T >= 1) with divisor D in run mode, `wd_rst_req` is high for exactly one cycle, T*D cycles after the reload, and the counter holds T again at that point.
- R4: When `pwr_mode` is 2'b01 (wait), the counter keeps counting if run enable and wait enable are both set, and expiry then raises the reset request. If either enable is clear, the counter reloads from the timeout register on every cycle.
- R5: When `pwr_mode` is 2'b10 (stop), the same rule applies with the stop enable bit in place of the wait enable bit. Codes 2'b00 and 2'b11 are run mode.
- R6: While `dbg_halt` is high, the counter and the prescaler hold their values.
- R7: While `dbg_halt` is high, control reads return bit 0 as 0. When debug ends, the stored run enable reads back and takes effect again.
- R8: Writing 0x5555 and then 0xAAAA to the service register at address 2 reloads the counter from the timeout register at address 1.
- R9: A 0xAAAA write that does not directly follow a 0x5555 write to the service register leaves the counter unchanged. Any other service value disarms the sequence.
- R10: If `ref_lost` is sampled high while loss-clock enable is set, a 7-bit counter starts on the next bus clock and never stops. `wd_rst_req` pulses for one cycle 127 cycles after the sampling edge, and again every 128 cycles after that.
- R11: `ref_lost` has no effect while loss-clock enable is clear.
- R12: In run mode with run enable clear, the counter reloads from the timeout register on every cycle, so a new timeout value shows at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 timeout, 2 service, 3 counter (read only) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| pwr_mode | input | 2 | Power state: 00 run, 01 wait, 10 stop, 11 run |
| dbg_halt | input | 1 | Chip held by debugger |
| ref_lost | input | 1 | Loss of reference clock indication |
| wd_rst_req | output | 1 | One-cycle reset request |

## Verification
A wrong counter or prescaler state shows on the counter readback within one divisor period. It also shows as a `wd_rst_req` pulse in the wrong cycle, so the bench checks the request on every cycle of a full countdown, not only at its end. A stale service-arm flag shows as a reload that should not happen, seen in the counter readback the cycle after the fire write. A missed mode or debug gate shows as a counter that moves, or fails to reload, within a few cycles of the mode change. A loss-clock counter that starts wrongly, or stops, shows as a pulse that comes early, late or missing within 128 cycles.

// File: rtl/lpwd_pkg.sv
package lpwd_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned PRE_W  = 10;
  localparam int unsigned LC_W   = 7;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_WAIT  = 2'd1,
    PM_STOP  = 2'd2,
    PM_SPARE = 2'd3
  } pmode_e;

  typedef struct packed {
    logic [1:0] psel;
    logic       lclk_en;
    logic       stop_en;
    logic       wait_en;
    logic       run_en;
  } ctrl_t;

  localparam int unsigned CTL_W = $bits(ctrl_t);

  localparam ctrl_t CTRL_RST = '{psel: 2'b11, lclk_en: 1'b0, stop_en: 1'b0,
                                 wait_en: 1'b0, run_en: 1'b1};

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_TMO  = 2'd1;
  localparam logic [ADDR_W-1:0] A_SVC  = 2'd2;
  localparam logic [ADDR_W-1:0] A_CNT  = 2'd3;

  localparam logic [DATA_W-1:0] KEY_ARM  = 16'h5555;
  localparam logic [DATA_W-1:0] KEY_FIRE = 16'hAAAA;

  // last prescaler count before a tick, per select code
  function automatic logic [PRE_W-1:0] pre_last(input logic [1:0] sel);
    logic [PRE_W-1:0] v;
    case (sel)
      2'd0:    v = PRE_W'(0);
      2'd1:    v = PRE_W'(15);
      2'd2:    v = PRE_W'(255);
      default: v = PRE_W'(1023);
    endcase
    return v;
  endfunction
endpackage

// File: rtl/lpwd_regs.sv
module lpwd_regs
  import lpwd_pkg::*;
#(
  parameter int unsigned CW = CNT_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          dbg,
  input  logic [CW-1:0] cnt,
  output ctrl_t         ctrl,
  output logic [CW-1:0] tmo,
  output logic          svc_reload,
  output logic [DW-1:0] rdata
);
  ctrl_t         ctrl_q, ctrl_d, ctrl_vis;
  logic [CW-1:0] tmo_q, tmo_d;
  logic          armed_q, armed_d;
  logic          ctrl_we, tmo_we, svc_we;

  always_comb begin
    ctrl_we    = wr && (addr == A_CTRL);
    tmo_we     = wr && (addr == A_TMO);
    svc_we     = wr && (addr == A_SVC);
    ctrl_d     = ctrl_we ? ctrl_t'(wdata[CTL_W-1:0]) : ctrl_q;
    tmo_d      = tmo_we ? CW'(wdata) : tmo_q;
    svc_reload = svc_we && armed_q && (wdata == KEY_FIRE);
    armed_d    = svc_we ? (wdata == KEY_ARM) : armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST;
      tmo_q   <= '1;
      armed_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      tmo_q   <= tmo_d;
      armed_q <= armed_d;
    end
  end

  always_comb begin
    ctrl_vis        = ctrl_q;
    ctrl_vis.run_en = ctrl_q.run_en & ~dbg;
    case (addr)
      A_CTRL:  rdata = {{(DW-CTL_W){1'b0}}, ctrl_vis};
      A_TMO:   rdata = DW'(tmo_q);
      A_CNT:   rdata = DW'(cnt);
      default: rdata = '0;
    endcase
  end

  assign ctrl = ctrl_q;
  assign tmo  = tmo_q;

  // R9: a fire write only reloads when the previous service write armed it
  a_r9_fire_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    svc_reload |-> $past(svc_we) && ($past(wdata) == KEY_ARM));
endmodule

// File: rtl/lpwd_prescale.sv
module lpwd_prescale
  import lpwd_pkg::*;
#(
  parameter int unsigned PW = PRE_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clr,
  input  logic [1:0] psel,
  output logic       tick
);
  logic [PW-1:0] pre_q, pre_d, last;

  always_comb begin
    last  = PW'(pre_last(psel));
    tick  = 1'b0;
    pre_d = pre_q;
    if (clr) begin
      pre_d = '0;
    end else if (run) begin
      if (pre_q >= last) begin
        tick  = 1'b1;
        pre_d = '0;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R6: prescaler frozen when not running and not cleared
  a_r6_pre_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(pre_q));
endmodule

// File: rtl/lpwd_count.sv
module lpwd_count
  import lpwd_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctrl_t         ctrl,
  input  logic [1:0]    pmode,
  input  logic          dbg,
  input  logic [CW-1:0] tmo,
  input  logic          svc_reload,
  input  logic          tick,
  output logic          active,
  output logic          reload,
  output logic [CW-1:0] cnt,
  output logic          expire
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          in_wait, in_stop, gate_off;

  always_comb begin
    in_wait  = (pmode == PM_WAIT);
    in_stop  = (pmode == PM_STOP);
    gate_off = !ctrl.run_en || (in_wait && !ctrl.wait_en) || (in_stop && !ctrl.stop_en);
    active   = !dbg && !gate_off;
    reload   = svc_reload || (!dbg && gate_off);
    expire   = 1'b0;
    cnt_d    = cnt_q;
    if (reload) begin
      cnt_d = tmo;
    end else if (tick) begin
      if (cnt_q <= CW'(1)) begin
        cnt_d  = tmo;
        expire = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R3: counter only steps down by one or reloads
  a_r3_step_or_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> (cnt_q == CW'($past(cnt_q) - 1'b1)) || (cnt_q == $past(tmo)));
  // R4: wait mode without both enables reloads
  a_r4_wait_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ((pmode == PM_WAIT) && !(ctrl.run_en && ctrl.wait_en) && !dbg) |=> (cnt_q == $past(tmo)));
  // R5: stop mode without both enables reloads
  a_r5_stop_reload: assert property (@(posedge clk) disable iff (!rst_n)
    ((pmode == PM_STOP) && !(ctrl.run_en && ctrl.stop_en) && !dbg) |=> (cnt_q == $past(tmo)));
  // R6: debug freezes the counter unless serviced
  a_r6_debug_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg && !svc_reload) |=> $stable(cnt_q));
endmodule

// File: rtl/lpwd_lossclk.sv
module lpwd_lossclk
  import lpwd_pkg::*;
#(
  parameter int unsigned LW = LC_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic lost,
  output logic term
);
  localparam logic [LW-1:0] PRE_TERM = {{(LW-1){1'b1}}, 1'b0};

  logic          run_q, run_d;
  logic [LW-1:0] lc_q, lc_d;

  always_comb begin
    run_d = run_q || (en && lost);
    lc_d  = run_q ? lc_q + 1'b1 : lc_q;
    term  = run_q && (lc_q == PRE_TERM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      lc_q  <= '0;
    end else begin
      run_q <= run_d;
      lc_q  <= lc_d;
    end
  end

  // R10: once started the backup counter never stops
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> run_q && (lc_q != $past(lc_q)));
  // R11: never starts without the enable
  a_r11_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !(en && lost)) |=> !run_q);
endmodule

// File: rtl/lpwd_top.sv
module lpwd_top
  import lpwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [1:0]        pwr_mode,
  input  logic              dbg_halt,
  input  logic              ref_lost,
  output logic              wd_rst_req
);
  logic [1:0]       rs_q;
  logic             srst_n;
  ctrl_t            ctrl;
  logic [CNT_W-1:0] tmo, cnt;
  logic             svc_reload, active, reload, tick, expire, lc_term, req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  lpwd_regs #(.CW(CNT_W), .DW(DATA_W), .AW(ADDR_W)) u_regs (
    .clk(clk), .rst_n(srst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .dbg(dbg_halt), .cnt(cnt), .ctrl(ctrl), .tmo(tmo), .svc_reload(svc_reload),
    .rdata(bus_rdata)
  );

  lpwd_prescale #(.PW(PRE_W)) u_pre (
    .clk(clk), .rst_n(srst_n), .run(active), .clr(reload), .psel(ctrl.psel),
    .tick(tick)
  );

  lpwd_count #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(srst_n), .ctrl(ctrl), .pmode(pwr_mode), .dbg(dbg_halt),
    .tmo(tmo), .svc_reload(svc_reload), .tick(tick), .active(active),
    .reload(reload), .cnt(cnt), .expire(expire)
  );

  lpwd_lossclk #(.LW(LC_W)) u_lc (
    .clk(clk), .rst_n(srst_n), .en(ctrl.lclk_en), .lost(ref_lost), .term(lc_term)
  );

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) req_q <= 1'b0;
    else         req_q <= expire | lc_term;
  end
  assign wd_rst_req = req_q;

  // R3: a request always follows an expiry or a backup terminal count
  a_r3_req_source: assert property (@(posedge clk) disable iff (!srst_n)
    wd_rst_req |-> ($past(cnt) <= CNT_W'(1)) || $past(lc_term));
endmodule

// File: tb/lpwd_top_tb.sv
`timescale 1ns/1ps
module lpwd_top_tb;
  logic        clk, rst_n, bus_wr, dbg_halt, ref_lost;
  logic [1:0]  bus_addr, pwr_mode;
  logic [15:0] bus_wdata, bus_rdata;
  logic        wd_rst_req;
  int          checks = 0;
  int          fails = 0;
  int          pulses = 0;
  logic        done = 1'b0;

  lpwd_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwr_mode(pwr_mode),
    .dbg_halt(dbg_halt), .ref_lost(ref_lost), .wd_rst_req(wd_rst_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) if (wd_rst_req) pulses++;

  function automatic int div_of(input int sel);
    case (sel)
      0: return 1;
      1: return 16;
      2: return 256;
      default: return 1024;
    endcase
  endfunction

  function automatic int exp_cnt(input int t, input int dv, input int k);
    return t - (k / dv);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    bus_addr = a;
    #1;
    d = int'(bus_rdata);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic service();
    wr(2'd2, 16'h5555);
    wr(2'd2, 16'hAAAA);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int v, c0, p0, bad;
    void'($urandom(32'd24681357));
    bus_wr = 0; bus_addr = 0; bus_wdata = 0; pwr_mode = 0;
    dbg_halt = 0; ref_lost = 0; rst_n = 0;
    step(4);
    rst_n = 1;
    step(4);

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 32'h31);
    rd(2'd1, v); chk("R1 timeout", v, 32'hFFFF);
    rd(2'd3, v); chk("R1 count", v, 32'hFFFF);
    chk("R1 no request", int'(wd_rst_req), 0);

    // R2 default divide-by-1024: one step after ~1024 cycles
    step(1100);
    rd(2'd3, v); chk("R2 div1024 step", v, 32'hFFFE);

    // R8 service reload, R2 divide-by-1
    wr(2'd0, 16'h0001);
    wr(2'd1, 16'd100);
    service();
    rd(2'd3, v); chk("R8 reload", v, 100);
    step(10);
    rd(2'd3, v); chk("R2 div1 rate", v, 90);

    // R9 bad service sequences
    rd(2'd3, c0);
    wr(2'd2, 16'hAAAA);
    rd(2'd3, v); chk("R9 lone fire", v, c0 - 1);
    wr(2'd2, 16'h5555);
    wr(2'd2, 16'h1234);
    wr(2'd2, 16'hAAAA);
    rd(2'd3, v); chk("R9 disarmed fire", v, c0 - 4);
    service();
    rd(2'd3, v); chk("R8 second reload", v, 100);

    // R12 run enable clear reloads continuously
    wr(2'd0, 16'h0000);
    step(5);
    rd(2'd3, v); chk("R12 hold at timeout", v, 100);
    wr(2'd1, 16'd50);
    step(2);
    rd(2'd3, v); chk("R12 new timeout", v, 50);

    // R4 wait mode
    pwr_mode = 2'b01;
    wr(2'd0, 16'h0001);
    step(5);
    rd(2'd3, v); chk("R4 wait gated", v, 50);
    wr(2'd0, 16'h0003);
    step(10);
    rd(2'd3, v); chk("R4 wait counting", v, 40);
    wr(2'd1, 16'd5);
    service();
    bad = -1;
    for (int k = 1; k <= 5; k++) begin
      step(1);
      if (int'(wd_rst_req) != ((k == 5) ? 1 : 0)) bad = k;
    end
    chk("R4 wait expiry pulse", bad, -1);
    rd(2'd3, v); chk("R4 reload after expiry", v, 5);

    // R5 stop mode
    pwr_mode = 2'b10;
    step(3);
    rd(2'd3, v); chk("R5 stop gated", v, 5);
    wr(2'd1, 16'd50);
    step(2);
    rd(2'd3, v); chk("R5 stop reload", v, 50);
    wr(2'd0, 16'h0005);
    step(8);
    rd(2'd3, v); chk("R5 stop counting", v, 42);

    // R6 / R7 debug
    pwr_mode = 2'b00;
    wr(2'd0, 16'h0001);
    service();
    step(5);
    rd(2'd3, v); chk("R6 before debug", v, 45);
    dbg_halt = 1;
    step(10);
    rd(2'd3, v); chk("R6 debug hold", v, 45);
    rd(2'd0, v); chk("R7 debug masks enable", v, 0);
    dbg_halt = 0;
    step(3);
    rd(2'd3, v); chk("R6 resume", v, 42);
    rd(2'd0, v); chk("R7 enable restored", v, 1);

    // R2 / R3 random countdowns
    for (int i = 0; i < 12; i++) begin
      int sel, dv, t, n, tot;
      sel = (($urandom % 4) == 0) ? 2 : int'($urandom % 2);
      dv  = div_of(sel);
      t   = (sel == 2) ? 1 + int'($urandom % 4) : 1 + int'($urandom % 30);
      tot = t * dv;
      n   = int'($urandom % tot);
      wr(2'd0, 16'((sel << 4) | 1));
      wr(2'd1, 16'(t));
      service();
      rd(2'd3, v); chk("R8 random reload", v, t);
      bad = -1;
      for (int k = 1; k <= tot; k++) begin
        step(1);
        if (k == n) begin
          rd(2'd3, v); chk("R2 random count", v, exp_cnt(t, dv, k));
        end
        if (int'(wd_rst_req) != ((k == tot) ? 1 : 0)) bad = k;
      end
      chk("R3 expiry timing", bad, -1);
      rd(2'd3, v); chk("R3 reload at expiry", v, t);
    end

    // R11 loss input ignored when disabled
    wr(2'd0, 16'h0031);
    wr(2'd1, 16'hFFFF);
    service();
    p0 = pulses;
    ref_lost = 1;
    step(300);
    ref_lost = 0;
    chk("R11 no request", pulses, p0);

    // R10 backup counter
    wr(2'd0, 16'h0039);
    ref_lost = 1;
    step(1);
    ref_lost = 0;
    bad = -1;
    for (int j = 1; j <= 260; j++) begin
      step(1);
      if (int'(wd_rst_req) != ((j == 127 || j == 255) ? 1 : 0)) bad = j;
    end
    chk("R10 backup pulses", bad, -1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule